// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block brings an SDRAM device out of power-up and into normal service. When a start request arrives while the block is idle, it first captures the refresh prescaler and refresh timer values. It then issues a fixed series of commands on the chip-select, row-strobe, column-strobe and write-enable lines. The series is one precharge of all banks, eight auto (CBR) refreshes and one mode-register load. It ends with a step that enters normal operation and turns on periodic refresh. A programmable minimum gap separates successive commands, and the command bus carries NOP for the whole of each gap.

Once refresh is enabled, an internal tick generator issues an auto-refresh command every (prescaler+1)·(timer+1) clock cycles. The generator is built from a prescaler counter that feeds a timer counter. A ready flag tells the rest of the memory controller that the device can now be used. Read and write traffic and page management are handled elsewhere.

Top module: `sdram_init_seq`

## Requirements
- R1: During and after reset, until a start is accepted, the command bus {csN,rasN,casN,weN} is NOP (0111), the address is zero, and both refreshEn and ready are low.
- R2: A start request sampled high while idle makes the next cycle carry precharge-all (0010) with the address equal to bit 10 alone (A10 high).
- R3: Exactly eight auto-refresh commands (0001) follow the precharge, each on its own command slot.
- R4: Successive sequence commands are exactly GAP_CYCLES cycles apart (default 8), and every cycle in between carries NOP (0111) with a zero address.
- R5: One slot after the eighth refresh, a mode-register load (0000) is issued with the address equal to MODE_WORD.
- R6: One slot after the mode-register load, refreshEn rises and no command is issued. ready rises exactly one cycle after refreshEn.
- R7: With refresh enabled, an auto-refresh (0001) is issued every K=(P+1)·(T+1) cycles, the first one K cycles after refreshEn rises. No periodic refresh is issued before that point.
- R8: The prescaler P and timer T are captured when the start is accepted. Later changes on those inputs have no effect on the refresh period.
- R9: A start request while the sequence is running, or after it has finished, is ignored and the command stream is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request to begin the power-up sequence |
| refPrescale | input | PRE_W | Refresh prescaler value P |
| refTimer | input | TMR_W | Refresh timer value T |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| sdAddr | output | ADDR_W | Address for precharge-all and mode-register load |
| refreshEn | output | 1 | Periodic refresh enabled |
| ready | output | 1 | Device initialised and usable |

## Verification
The bench replays the whole sequence for several prescaler and timer pairs, including the case where both are zero and a refresh fires every cycle. It compares every output in every cycle against a timeline computed from the slot index. An off-by-one gap counter would shift every later command by a cycle. A refresh counter that stops at seven or nine would place the mode-register load in the wrong slot. A tick generator that starts before enable or miscounts its wrap would misplace the periodic refreshes. The bench also changes the prescaler and timer inputs after the start and pulses start in mid-sequence and after completion. A design that does not latch those values, or that restarts, then breaks the expected timeline.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // {csN, rasN, casN, weN}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } sdCmd_t;

  // strobes from control to datapath
  typedef struct packed {
    logic captureCfg;
    logic issuePre;
    logic issueRef;
    logic issueMrs;
    logic issueNorm;
  } seqStrobe_t;

endpackage

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl
  import sdram_init_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       gapDone,
  input  logic       refDone,
  output seqStrobe_t strobe,
  output logic       ready
);

  typedef enum logic [1:0] {S_IDLE, S_REFS, S_NORM, S_RUN} seqState_t;

  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      S_IDLE: if (startReq) begin
        strobe.captureCfg = 1'b1;
        strobe.issuePre   = 1'b1;
        stateNext         = S_REFS;
      end
      S_REFS: if (gapDone) begin
        if (refDone) begin
          strobe.issueMrs = 1'b1;
          stateNext       = S_NORM;
        end else begin
          strobe.issueRef = 1'b1;
        end
      end
      S_NORM: if (gapDone) begin
        strobe.issueNorm = 1'b1;
        stateNext        = S_RUN;
      end
      default: stateNext = S_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      ready <= 1'b0;
    end else begin
      state <= stateNext;
      ready <= (state == S_RUN);
    end
  end

  // R9: once running, the sequence never returns to idle
  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RUN) |=> (state == S_RUN));

endmodule

// File: rtl/sdram_init_dp.sv
module sdram_init_dp
  import sdram_init_pkg::*;
#(
  parameter int unsigned PRE_W      = 8,
  parameter int unsigned TMR_W      = 8,
  parameter int unsigned GAP_CYCLES = 8,
  parameter int unsigned REF_COUNT  = 8,
  parameter int unsigned ADDR_W     = 13,
  parameter logic [ADDR_W-1:0] MODE_WORD = 13'h0032
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [PRE_W-1:0]  refPrescale,
  input  logic [TMR_W-1:0]  refTimer,
  output sdCmd_t            cmdQ,
  output logic [ADDR_W-1:0] addrQ,
  output logic              refreshEn,
  output logic              gapDone,
  output logic              refDone
);

  localparam int unsigned GAP_W = (GAP_CYCLES > 2) ? $clog2(GAP_CYCLES) : 1;
  localparam int unsigned REF_W = $clog2(REF_COUNT + 1);
  localparam logic [GAP_W-1:0]  GAP_INIT = GAP_W'(GAP_CYCLES - 1);
  localparam logic [REF_W-1:0]  REF_LAST = REF_W'(REF_COUNT);
  localparam logic [ADDR_W-1:0] A10_ONLY = ADDR_W'(1) << 10;

  logic [GAP_W-1:0] gapCnt;
  logic [REF_W-1:0] refCnt;
  logic [PRE_W-1:0] preLim, preCnt;
  logic [TMR_W-1:0] tmrLim, tmrCnt;
  logic             anyIssue, tick;

  assign anyIssue = strobe.issuePre | strobe.issueRef | strobe.issueMrs | strobe.issueNorm;
  assign gapDone  = (gapCnt == '0);
  assign refDone  = (refCnt == REF_LAST);
  assign tick     = refreshEn && (preCnt == preLim) && (tmrCnt == tmrLim);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ      <= CMD_NOP;
      addrQ     <= '0;
      gapCnt    <= '0;
      refCnt    <= '0;
      refreshEn <= 1'b0;
      preLim    <= '0;
      tmrLim    <= '0;
      preCnt    <= '0;
      tmrCnt    <= '0;
    end else begin
      cmdQ  <= CMD_NOP;
      addrQ <= '0;
      if (strobe.captureCfg) begin
        preLim <= refPrescale;
        tmrLim <= refTimer;
      end
      if (anyIssue)          gapCnt <= GAP_INIT;
      else if (gapCnt != '0) gapCnt <= gapCnt - 1'b1;
      if (strobe.issuePre) begin
        cmdQ   <= CMD_PRE;
        addrQ  <= A10_ONLY;
        refCnt <= '0;
      end
      if (strobe.issueRef) begin
        cmdQ   <= CMD_REF;
        refCnt <= refCnt + 1'b1;
      end
      if (strobe.issueMrs) begin
        cmdQ  <= CMD_MRS;
        addrQ <= MODE_WORD;
      end
      if (strobe.issueNorm) refreshEn <= 1'b1;
      if (refreshEn) begin
        if (tick) begin
          preCnt <= '0;
          tmrCnt <= '0;
          cmdQ   <= CMD_REF;
        end else if (preCnt == preLim) begin
          preCnt <= '0;
          tmrCnt <= tmrCnt + 1'b1;
        end else begin
          preCnt <= preCnt + 1'b1;
        end
      end
    end
  end

  // R4: at most one command strobe per cycle
  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.issuePre, strobe.issueRef, strobe.issueMrs, strobe.issueNorm}));
  // R4: later steps only once the gap has elapsed
  p_gap_respected_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.issueRef || strobe.issueMrs || strobe.issueNorm) |-> (gapCnt == '0));
  // R5: mode load only after the full refresh count
  p_mrs_after_refs_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issueMrs |-> (refCnt == REF_LAST));
  // R6: refresh enable is sticky
  p_refen_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    refreshEn |=> refreshEn);

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned PRE_W      = 8,
  parameter int unsigned TMR_W      = 8,
  parameter int unsigned GAP_CYCLES = 8,
  parameter int unsigned REF_COUNT  = 8,
  parameter int unsigned ADDR_W     = 13,
  parameter logic [ADDR_W-1:0] MODE_WORD = 13'h0032
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [PRE_W-1:0]  refPrescale,
  input  logic [TMR_W-1:0]  refTimer,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [ADDR_W-1:0] sdAddr,
  output logic              refreshEn,
  output logic              ready
);

  seqStrobe_t strobe;
  sdCmd_t     cmdQ;
  logic       gapDone, refDone;

  sdram_init_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .gapDone(gapDone), .refDone(refDone),
    .strobe(strobe), .ready(ready)
  );

  sdram_init_dp #(
    .PRE_W(PRE_W), .TMR_W(TMR_W), .GAP_CYCLES(GAP_CYCLES),
    .REF_COUNT(REF_COUNT), .ADDR_W(ADDR_W), .MODE_WORD(MODE_WORD)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .refPrescale(refPrescale), .refTimer(refTimer),
    .cmdQ(cmdQ), .addrQ(sdAddr), .refreshEn(refreshEn),
    .gapDone(gapDone), .refDone(refDone)
  );

  assign {csN, rasN, casN, weN} = cmdQ;

  // R6: ready never precedes refresh enable
  p_ready_needs_refen_r6: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> refreshEn);
  // R6: ready rises the cycle after refresh enable rises
  p_ready_follows_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(refreshEn) |=> ready);

endmodule

// File: tb/test_sdram_init_seq.sv
module test_sdram_init_seq;

  localparam int G = 8;
  localparam logic [12:0] MODE = 13'h0032;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [7:0]  refPrescale = '0;
  logic [7:0]  refTimer = '0;
  logic        csN, rasN, casN, weN, refreshEn, ready;
  logic [12:0] sdAddr;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  sdram_init_seq i_sdram_init_seq (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .refPrescale(refPrescale), .refTimer(refTimer),
    .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .sdAddr(sdAddr), .refreshEn(refreshEn), .ready(ready)
  );

  task automatic check(input string req, input logic [18:0] act, input logic [18:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual cmd/addr/en/rdy=%b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [18:0] expected(int k, int kk);
    logic [3:0]  c = 4'b0111;
    logic [12:0] a = '0;
    logic        en = (k >= 10*G);
    logic        rd = (k >= 10*G + 1);
    if (k < 10*G && k % G == 0) begin
      if (k == 0) begin c = 4'b0010; a = 13'h0400; end
      else if (k / G <= 8) c = 4'b0001;
      else begin c = 4'b0000; a = MODE; end
    end
    if (k > 10*G && (k - 10*G) % kk == 0) c = 4'b0001;
    return {c, a, en, rd};
  endfunction

  function automatic string tagOf(int k);
    if (k == 0) return "R2";
    if (k < 9*G) return (k % G == 0) ? "R3" : "R4";
    if (k < 10*G) return (k == 9*G) ? "R5" : "R4";
    if (k <= 10*G + 1) return "R6";
    return "R7/R8/R9";
  endfunction

  task automatic runOne(input int p, input int t);
    int kk = (p + 1) * (t + 1);
    int lim = 10*G + 3*kk + 6;
    rstN = 1'b0;
    startReq = 1'b0;
    refPrescale = 8'(p);
    refTimer = 8'(t);
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {csN, rasN, casN, weN, sdAddr, refreshEn, ready}, {4'b0111, 13'h0, 1'b0, 1'b0});
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", {csN, rasN, casN, weN, sdAddr, refreshEn, ready}, {4'b0111, 13'h0, 1'b0, 1'b0});
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    for (int k = 0; k <= lim; k++) begin
      check(tagOf(k), {csN, rasN, casN, weN, sdAddr, refreshEn, ready}, expected(k, kk));
      // R8: disturb the config inputs after capture
      if (k == 1) begin refPrescale = 8'(p + 3); refTimer = 8'(t + 2); end
      // R9: start pulses while busy and after completion
      startReq = (k == 5) || (k == 3*G + 2) || (k == 10*G + 3);
      @(negedge clk);
    end
    startReq = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nFails++;
    nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    runOne(0, 0);
    runOne(1, 2);
    runOne(3, 0);
    runOne(2, 3);
    runOne(4, 1);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule